// File: doc/BRIEF.md
# Block Carry-Skip Adder

This block adds two unsigned operands and a carry-in, producing a sum of the same width and a carry-out. The operand width is cut into groups. Inside each group the carry ripples from bit to bit. Each group also forms a group-propagate flag, which is the AND of the per-bit propagate terms. When that flag is set, a multiplexer passes the group's carry-in straight to its carry-out and the ripple chain is bypassed. When the flag is clear, the group itself generates or kills the carry, and its carry-in cannot change its carry-out.

The default build is 16 bits in four groups of 4: bits 3..0, 7..4, 11..8 and 15..12. Group sizes can be set one by one through a packed size vector, for example with larger groups in the middle of the word. A second skip level can also be enabled. It joins a fixed number of neighbouring groups into a span. The span's carry-out bypasses all of them when every one of their propagate flags is set.

The block is purely combinational, with no clock, reset or handshake. It is placed between registers of the surrounding pipeline. The size vector must add up to the word width, and elaboration stops with an error if it does not.

Top module: `csk_adder`

## Requirements
- R1: `{c_out, sum}` equals `opa + opb + c_in` taken as an unsigned (WIDTH+1)-bit value, for every operand pair and both carry-in values.
- R2: When every bit of a group has `opa ^ opb` set, the group carry-out equals the group carry-in. With all WIDTH bits propagating, c_in=0 gives sum all ones and c_out 0, and c_in=1 gives sum 0 and c_out 1.
- R3: When any bit of a group does not propagate, the group carry-out equals the carry that the group's own bits produce with a zero carry-in. Example: opa=opb=0 with c_in=1 gives sum 1 and c_out 0.
- R4: With default parameters the block is 16 bits wide and the groups are bits 3..0, 7..4, 11..8 and 15..12. Patterns whose carries cross each 4-bit boundary give the exact sum.
- R5: For any group-size vector (8 bits per group, group 0 in the lowest field) that adds up to WIDTH, R1 holds. Example: sizes 1,3,2 over a 6-bit word, checked for all operand and carry-in combinations.
- R6: With the second skip level enabled, a span of SUPER groups whose propagate flags are all set passes its carry-in to its carry-out, and R1 still holds.
- R7: A carry generated at bit 0 reaches c_out when all higher bits propagate. Example: opa=16'h0001, opb=16'hFFFF, c_in=0 gives sum 0 and c_out 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opa | input | WIDTH | First operand |
| opb | input | WIDTH | Second operand |
| c_in | input | 1 | Carry into bit 0 |
| sum | output | WIDTH | Sum bits |
| c_out | output | 1 | Carry out of the top bit |

## Verification
Random operand pairs exercise the mix of generate, kill and propagate bits that real data has, so most groups resolve their carry locally. Operand pairs that propagate across the whole word, or across one chosen group or span with the other bits random, are the only inputs that make the bypass multiplexers decide the result. These cases separate a correct skip path from one that is inverted or selects the wrong carry. A carry generated at bit 0 and carried to the top bit covers the longest path. An exhaustive run of a small word with unequal groups catches any offset or boundary error in the variable-size layout.

// File: rtl/csk_pkg.sv
package csk_pkg;
  localparam int MAX_GRP   = 32;
  localparam int SIZE_BITS = 8;
  localparam int VEC_BITS  = MAX_GRP * SIZE_BITS;

  // size of group k from a packed size vector (group 0 in the low field)
  function automatic int grp_size(logic [VEC_BITS-1:0] sizes, int k);
    return int'(sizes[SIZE_BITS*k +: SIZE_BITS]);
  endfunction

  // bit position where group k starts
  function automatic int grp_offset(logic [VEC_BITS-1:0] sizes, int k);
    int s;
    s = 0;
    for (int i = 0; i < k; i++) s += grp_size(sizes, i);
    return s;
  endfunction
endpackage

// File: rtl/csk_group.sv
module csk_group #(
  parameter int W = 4
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         ci,
  output logic [W-1:0] s,
  output logic         co,
  output logic         bp
);
  logic [W-1:0] prop;
  logic [W-1:0] gen;
  logic [W:0]   rc;

  assign prop  = a ^ b;
  assign gen   = a & b;
  assign rc[0] = ci;

  for (genvar i = 0; i < W; i++) begin : g_bit
    assign rc[i+1] = gen[i] | (prop[i] & rc[i]);
    assign s[i]    = prop[i] ^ rc[i];
  end

  assign bp = &prop;
  // bypass: when the whole group propagates, the carry-in skips the chain
  assign co = bp ? ci : rc[W];
endmodule

// File: rtl/csk_span.sv
module csk_span #(
  parameter int N = 2
) (
  input  logic [N-1:0] grp_bp,
  input  logic         span_ci,
  input  logic         chain_co,
  output logic         span_co,
  output logic         span_bp
);
  assign span_bp = &grp_bp;
  assign span_co = span_bp ? span_ci : chain_co;
endmodule

// File: rtl/csk_adder.sv
module csk_adder
  import csk_pkg::*;
#(
  parameter int                             WIDTH = 16,
  parameter int                             NGRP  = 4,
  parameter logic [NGRP*SIZE_BITS-1:0]      GSIZE = {NGRP{8'd4}},
  parameter bit                             SKIP2 = 1'b0,
  parameter int                             SUPER = 2
) (
  input  logic [WIDTH-1:0] opa,
  input  logic [WIDTH-1:0] opb,
  input  logic             c_in,
  output logic [WIDTH-1:0] sum,
  output logic             c_out
);
  localparam logic [VEC_BITS-1:0] SZV   = VEC_BITS'(GSIZE);
  localparam int                  NSPAN = (NGRP / SUPER > 0) ? NGRP / SUPER : 1;

  if (grp_offset(SZV, NGRP) != WIDTH) begin : g_bad_sizes
    $error("csk_adder: group sizes do not add up to WIDTH");
  end
  if (NGRP > MAX_GRP) begin : g_bad_count
    $error("csk_adder: too many groups");
  end
  if (SKIP2 && (NGRP % SUPER != 0)) begin : g_bad_span
    $error("csk_adder: NGRP must be a multiple of SUPER");
  end

  logic [NGRP-1:0]  gci;
  logic [NGRP-1:0]  gco;
  logic [NGRP-1:0]  gbp;
  logic [NSPAN-1:0] spn_co;
  logic [NSPAN-1:0] spn_bp;

  for (genvar k = 0; k < NGRP; k++) begin : g_grp
    localparam int OFF = grp_offset(SZV, k);
    localparam int SZ  = grp_size(SZV, k);
    csk_group #(.W(SZ)) u_grp (
      .a  (opa[OFF +: SZ]),
      .b  (opb[OFF +: SZ]),
      .ci (gci[k]),
      .s  (sum[OFF +: SZ]),
      .co (gco[k]),
      .bp (gbp[k])
    );
    if (k == 0) begin : g_first
      assign gci[k] = c_in;
    end else if (SKIP2 && (k % SUPER == 0)) begin : g_from_span
      assign gci[k] = spn_co[k/SUPER - 1];
    end else begin : g_from_grp
      assign gci[k] = gco[k-1];
    end
  end

  if (SKIP2) begin : g_lvl2
    for (genvar j = 0; j < NSPAN; j++) begin : g_span
      csk_span #(.N(SUPER)) u_span (
        .grp_bp   (gbp[j*SUPER +: SUPER]),
        .span_ci  (gci[j*SUPER]),
        .chain_co (gco[j*SUPER + SUPER - 1]),
        .span_co  (spn_co[j]),
        .span_bp  (spn_bp[j])
      );
    end
    assign c_out = spn_co[NSPAN-1];
  end else begin : g_lvl1
    assign spn_co = '0;
    assign spn_bp = '0;
    assign c_out  = gco[NGRP-1];
  end
endmodule

// File: rtl/csk_checker.sv
module csk_checker
  import csk_pkg::*;
#(
  parameter int                        WIDTH = 16,
  parameter int                        NGRP  = 4,
  parameter logic [NGRP*SIZE_BITS-1:0] GSIZE = {NGRP{8'd4}},
  parameter bit                        SKIP2 = 1'b0,
  parameter int                        SUPER = 2,
  parameter int                        NSPAN = 1
) (
  input logic [WIDTH-1:0] opa,
  input logic [WIDTH-1:0] opb,
  input logic             c_in,
  input logic [WIDTH-1:0] sum,
  input logic             c_out,
  input logic [NGRP-1:0]  gci,
  input logic [NGRP-1:0]  gco,
  input logic [NGRP-1:0]  gbp,
  input logic [NSPAN-1:0] spn_co,
  input logic [NSPAN-1:0] spn_bp
);
  localparam logic [VEC_BITS-1:0] SZV = VEC_BITS'(GSIZE);

  function automatic logic grp_carry(int k, logic ci);
    logic [WIDTH:0] mask, ag, bg, t;
    int off, sz;
    off  = grp_offset(SZV, k);
    sz   = grp_size(SZV, k);
    mask = {(WIDTH+1){1'b1}} >> (WIDTH + 1 - sz);
    ag   = ({1'b0, opa} >> off) & mask;
    bg   = ({1'b0, opb} >> off) & mask;
    t    = ag + bg + {{WIDTH{1'b0}}, ci};
    return t[sz];
  endfunction

  logic [WIDTH:0] ref_total;
  assign ref_total = {1'b0, opa} + {1'b0, opb} + {{WIDTH{1'b0}}, c_in};

  always_comb begin
    AST_SUM_EXACT: assert ({c_out, sum} == ref_total); // R1
    for (int k = 0; k < NGRP; k++) begin
      AST_GRP_PASS: assert (!gbp[k] || (gco[k] == gci[k])); // R2
      AST_GRP_CARRY: assert (gco[k] == grp_carry(k, gci[k])); // R2
      AST_GRP_LOCAL: assert (gbp[k] || (gco[k] == grp_carry(k, 1'b0))); // R3
    end
    if (SKIP2) begin
      for (int j = 0; j < NSPAN; j++) begin
        AST_SPAN_PASS: assert (!spn_bp[j] || (spn_co[j] == gci[j*SUPER])); // R6
        AST_SPAN_AGREE: assert (spn_co[j] == gco[j*SUPER + SUPER - 1]); // R6
      end
    end
  end
endmodule

bind csk_adder csk_checker #(
  .WIDTH(WIDTH), .NGRP(NGRP), .GSIZE(GSIZE), .SKIP2(SKIP2),
  .SUPER(SUPER), .NSPAN(NSPAN)
) u_chk (
  .opa(opa), .opb(opb), .c_in(c_in), .sum(sum), .c_out(c_out),
  .gci(gci), .gco(gco), .gbp(gbp), .spn_co(spn_co), .spn_bp(spn_bp)
);

// File: tb/tb_csk_adder.sv
module tb_csk_adder;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;  // 250 MHz

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  // default build: 16 bits, 4x4 groups, one skip level
  logic [15:0] a16, b16, s16;
  logic        ci16, co16;
  csk_adder dut (.opa(a16), .opb(b16), .c_in(ci16), .sum(s16), .c_out(co16));

  // uneven groups 1,3,2 over 6 bits
  logic [5:0] a6, b6, s6;
  logic       ci6, co6;
  csk_adder #(.WIDTH(6), .NGRP(3), .GSIZE({8'd2, 8'd3, 8'd1})) dut_v (
    .opa(a6), .opb(b6), .c_in(ci6), .sum(s6), .c_out(co6));

  // uneven groups 2,5,5,4 with a second skip level over pairs
  logic [15:0] a2, b2, s2;
  logic        ci2, co2;
  csk_adder #(.WIDTH(16), .NGRP(4), .GSIZE({8'd4, 8'd5, 8'd5, 8'd2}),
              .SKIP2(1'b1), .SUPER(2)) dut_s2 (
    .opa(a2), .opb(b2), .c_in(ci2), .sum(s2), .c_out(co2));

  function automatic logic [16:0] ref16(logic [15:0] a, logic [15:0] b, logic c);
    return {1'b0, a} + {1'b0, b} + {16'd0, c};
  endfunction

  function automatic logic [6:0] ref6(logic [5:0] a, logic [5:0] b, logic c);
    return {1'b0, a} + {1'b0, b} + {6'd0, c};
  endfunction

  task automatic cmp(string req, logic [16:0] act, logic [16:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic run16(string req, logic [15:0] a, logic [15:0] b, logic c);
    @(negedge clk);
    a16 = a; b16 = b; ci16 = c;
    a2 = a;  b2 = b;  ci2 = c;
    #1;
    cmp(req, {co16, s16}, ref16(a, b, c));
    cmp({req, "/R6"}, {co2, s2}, ref16(a, b, c));
  endtask

  initial begin
    logic [15:0] ra, rb, m;
    int seed;
    a16 = '0; b16 = '0; ci16 = 1'b0;
    a2 = '0;  b2 = '0;  ci2 = 1'b0;
    a6 = '0;  b6 = '0;  ci6 = 1'b0;
    seed = int'($urandom(32'h0C5C_A11D));
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    #1;
    // quiet state: zero operands give zero result
    cmp("R1 zero", {co16, s16}, 17'd0);

    // R2: whole word propagates
    run16("R2 allprop c0", 16'hA5C3, 16'h5A3C, 1'b0);
    cmp("R2 allprop sum", {co16, s16}, {1'b0, 16'hFFFF});
    run16("R2 allprop c1", 16'hA5C3, 16'h5A3C, 1'b1);
    cmp("R2 allprop wrap", {co16, s16}, 17'h10000);
    // R3: kill everywhere, carry-in only affects bit 0
    run16("R3 kill", 16'h0000, 16'h0000, 1'b1);
    cmp("R3 kill value", {co16, s16}, 17'd1);
    // R7: carry from bit 0 to the top
    run16("R7 long", 16'h0001, 16'hFFFF, 1'b0);
    cmp("R7 long value", {co16, s16}, 17'h10000);
    run16("R7 cin", 16'hFFFF, 16'h0000, 1'b1);
    // R4: carries crossing each 4-bit boundary
    for (int k = 1; k < 4; k++) begin
      m = 16'hF << (4 * k);
      run16("R4 boundary", (16'h8 << (4 * (k - 1))) | m, (16'h8 << (4 * (k - 1))), 1'b0);
      run16("R4 boundary gen", 16'h000F << (4 * (k - 1)), 16'h0001 << (4 * (k - 1)), 1'b1);
    end
    // R2: one group propagating, rest random
    for (int i = 0; i < 400; i++) begin
      int k;
      k  = i % 4;
      m  = 16'hF << (4 * k);
      ra = 16'($urandom);
      rb = 16'($urandom);
      rb = (rb & ~m) | (~ra & m);
      run16("R2 group", ra, rb, 1'($urandom));
    end
    // R6: low span of dut_s2 (bits 6..0) fully propagating
    for (int i = 0; i < 300; i++) begin
      ra = 16'($urandom);
      rb = 16'($urandom);
      rb = (rb & 16'hFF80) | (~ra & 16'h007F);
      run16("R6 span", ra, rb, 1'($urandom));
    end
    // R1: random operands
    for (int i = 0; i < 3000; i++) begin
      run16("R1 random", 16'($urandom), 16'($urandom), 1'($urandom));
    end
    // R1: all-propagate pairs with random values
    for (int i = 0; i < 200; i++) begin
      ra = 16'($urandom);
      run16("R1 allprop", ra, ~ra, 1'($urandom));
    end
    // R5: exhaustive 6-bit with unequal groups
    for (int x = 0; x < 64; x++) begin
      for (int y = 0; y < 64; y++) begin
        for (int c = 0; c < 2; c++) begin
          @(negedge clk);
          a6 = 6'(x); b6 = 6'(y); ci6 = 1'(c);
          #1;
          cmp("R5 exhaustive", {10'd0, co6, s6}, {10'd0, ref6(6'(x), 6'(y), 1'(c))});
        end
      end
    end
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule